// File: doc/BRIEF.md
# Programmable Interrupt Stimulus Port

This block is a test-harness peripheral that sits beside an 8-bit CPU core of the classic eight-bit microprocessor family. It watches the CPU's I/O write strobe and port address. Test software can then ask for an interrupt at a chosen cycle offset and choose which instruction the CPU receives when it acknowledges that interrupt. A delay written to one port starts a countdown. When the countdown ends, the interrupt request pulses high for a single clock.

A second port selects one of eight vector slots. Each slot is four bytes long and sits at a fixed base address in memory. During the acknowledge fetches that follow a pulse, the block drives the data bus with the bytes of the selected slot, one byte per acknowledge read and in order. This lets a vector be a one-byte opcode or a two- or three-byte instruction such as a jump or a call.

A third port records the test outcome. Its first write latches a done flag, and also a pass flag that is set when the written value is the success code. A self-checking bench can stop on these flags.

Top module: `irq_stim_port`

## Requirements
- R1: After reset, intr, ack_oe, done and pass are all 0, and ack_data is 0.
- R2: A write of value N to port 11h is sampled at clock edge k. intr is then 1 exactly in the cycle that follows edge k+N+1, and 0 in every cycle from edge k up to edge k+N+1.
- R3: Each countdown produces a single one-cycle intr pulse and then disarms. intr stays 0 until port 11h is written again, whether or not an acknowledge follows. The CPU's run or halt state plays no part, since the block has no such input.
- R4: A write to port 11h while a countdown is running restarts it from the new value. This also holds when the write is sampled at the very edge where the old count would have fired; that pulse is suppressed.
- R5: A write to port 10h stores the low 3 bits of the data as the source number S. The vector address presented on vec_addr is 40h + S*4 + offset.
- R6: The byte offset is forced to 0 at the edge that raises intr. It then increases by one at each edge where inta and rd are both 1, so three acknowledge reads return slot bytes 0, 1 and 2 in order.
- R7: ack_oe is 1 and ack_data equals vec_rdata only while inta and rd are both 1. Otherwise ack_oe and ack_data are 0. An acknowledge cycle with rd at 0 leaves the offset unchanged.
- R8: The first write to port 20h sets done to 1. It also sets pass to 1 if the data is 55h and to 0 for any other value, such as AAh. Later writes to port 20h change neither flag.
- R9: A write to any other port address, or a port address presented with io_wr at 0, changes neither the source number, nor the countdown, nor the outcome flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_wr | input | 1 | CPU I/O write strobe |
| io_addr | input | 8 | CPU I/O port address |
| io_wdata | input | 8 | CPU I/O write data |
| inta | input | 1 | CPU interrupt acknowledge strobe |
| rd | input | 1 | CPU read strobe |
| vec_rdata | input | 8 | Byte read from memory at vec_addr |
| intr | output | 1 | Interrupt request pulse to the CPU |
| vec_addr | output | 16 | Memory address of the current vector byte |
| ack_data | output | 8 | Byte driven to the CPU during acknowledge reads |
| ack_oe | output | 1 | Data bus enable for ack_data |
| done | output | 1 | Outcome port has been written |
| pass | output | 1 | Outcome value was the success code |

## Verification
Two events can land on the same edge: the countdown reaching zero and a fresh write to the delay port. The bench times a second delay write so that it is sampled exactly at the edge where the first count would fire. It then checks, cycle by cycle, that no pulse appears there and that the pulse arrives N+1 edges after the second write. A second overlap is an acknowledge cycle without a read strobe between real acknowledge reads. The bench confirms that the bus stays undriven and that the next read still returns the byte it would have returned anyway.

// File: rtl/irq_stim_pkg.sv
package irq_stim_pkg;

   // One flag per decoded harness port, at most one set per cycle.
   typedef struct packed {
      logic src;
      logic dly;
      logic fin;
   } port_hit_t;

endpackage

// File: rtl/irq_port_decode.sv
module irq_port_decode
   import irq_stim_pkg::*;
#(
   parameter int          AW       = 8,
   parameter logic [AW-1:0] PORT_SRC = 'h10,
   parameter logic [AW-1:0] PORT_DLY = 'h11,
   parameter logic [AW-1:0] PORT_END = 'h20
) (
   input  logic          io_wr,
   input  logic [AW-1:0] io_addr,
   output port_hit_t     hit
);

   if (PORT_SRC == PORT_DLY || PORT_SRC == PORT_END || PORT_DLY == PORT_END) begin : g_bad_ports
      $error("irq_port_decode: port addresses must differ");
   end

   always_comb begin
      hit.src = io_wr && (io_addr == PORT_SRC);
      hit.dly = io_wr && (io_addr == PORT_DLY);
      hit.fin = io_wr && (io_addr == PORT_END);
   end

endmodule

// File: rtl/irq_delay_timer.sv
module irq_delay_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             fire,
   output logic             intr
);

   if (CNT_W < 1) begin : g_bad_w
      $error("irq_delay_timer: CNT_W must be positive");
   end

   logic             armed;
   logic [CNT_W-1:0] cnt;

   // A load on the expiry edge wins over the pulse.
   assign fire = armed && (cnt == '0) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         armed <= 1'b0;
         cnt   <= '0;
         intr  <= 1'b0;
      end else begin
         intr <= fire;
         if (load) begin
            armed <= 1'b1;
            cnt   <= load_val;
         end else if (fire) begin
            armed <= 1'b0;
         end else if (armed) begin
            cnt <= cnt - CNT_W'(1);
         end
      end
   end

   AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      intr |=> !intr); // R3
   AST_PULSE_DISARMS: assert property (@(posedge clk) disable iff (!rst_n)
      (intr && !$past(load)) |-> !armed); // R3
   AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && !load && cnt != '0) |=> (cnt == $past(cnt) - CNT_W'(1))); // R2
   AST_RELOAD: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> (armed && !intr)); // R4

endmodule

// File: rtl/irq_vector_feed.sv
module irq_vector_feed #(
   parameter int DATA_W     = 8,
   parameter int MEM_AW     = 16,
   parameter int VEC_BASE   = 'h40,
   parameter int NUM_SRC    = 8,
   parameter int SLOT_BYTES = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              src_wr,
   input  logic [DATA_W-1:0] src_val,
   input  logic              restart,
   input  logic              inta,
   input  logic              rd,
   input  logic [DATA_W-1:0] vec_rdata,
   output logic [MEM_AW-1:0] vec_addr,
   output logic [DATA_W-1:0] ack_data,
   output logic              ack_oe
);

   localparam int SRC_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;
   localparam int OFF_W = (SLOT_BYTES > 1) ? $clog2(SLOT_BYTES) : 1;

   if (NUM_SRC < 2 || (NUM_SRC & (NUM_SRC - 1)) != 0) begin : g_bad_src
      $error("irq_vector_feed: NUM_SRC must be a power of two >= 2");
   end
   if (SLOT_BYTES < 1 || (SLOT_BYTES & (SLOT_BYTES - 1)) != 0) begin : g_bad_slot
      $error("irq_vector_feed: SLOT_BYTES must be a power of two");
   end
   if (SRC_W > DATA_W) begin : g_bad_width
      $error("irq_vector_feed: source field wider than data bus");
   end

   logic [SRC_W-1:0] src;
   logic [OFF_W-1:0] off;
   logic             rd_ack;

   assign rd_ack = inta && rd;

   always_ff @(posedge clk) begin
      if (!rst_n)      src <= '0;
      else if (src_wr) src <= src_val[SRC_W-1:0];
   end

   if (SLOT_BYTES == 1) begin : g_single_byte
      assign off = '0;
   end else begin : g_multi_byte
      always_ff @(posedge clk) begin
         if (!rst_n)       off <= '0;
         else if (restart) off <= '0;
         else if (rd_ack)  off <= off + OFF_W'(1);
      end

      AST_OFF_STEP: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_ack && !restart) |=> (off == $past(off) + OFF_W'(1))); // R6
      AST_OFF_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
         (!rd_ack && !restart) |=> $stable(off)); // R7
   end

   assign vec_addr = MEM_AW'(VEC_BASE) + MEM_AW'(src) * MEM_AW'(SLOT_BYTES) + MEM_AW'(off);
   assign ack_oe   = rd_ack;
   assign ack_data = rd_ack ? vec_rdata : '0;

   AST_OFF_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
      restart |=> (off == '0)); // R6
   AST_SRC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !src_wr |=> $stable(src)); // R9
   AST_ADDR_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (vec_addr >= MEM_AW'(VEC_BASE)) &&
      (vec_addr < MEM_AW'(VEC_BASE) + MEM_AW'(NUM_SRC) * MEM_AW'(SLOT_BYTES))); // R5

endmodule

// File: rtl/irq_outcome_latch.sv
module irq_outcome_latch #(
   parameter int              DATA_W    = 8,
   parameter logic [DATA_W-1:0] PASS_CODE = 'h55
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [DATA_W-1:0] wdata,
   output logic              done,
   output logic              pass
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done <= 1'b0;
         pass <= 1'b0;
      end else if (wr && !done) begin
         done <= 1'b1;
         pass <= (wdata == PASS_CODE);
      end
   end

   AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (done && $stable(pass))); // R8
   AST_PASS_NEEDS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      pass |-> done); // R8

endmodule

// File: rtl/irq_stim_port.sv
module irq_stim_port
   import irq_stim_pkg::*;
#(
   parameter int          DATA_W     = 8,
   parameter int          PORT_AW    = 8,
   parameter int          MEM_AW     = 16,
   parameter int          VEC_BASE   = 'h40,
   parameter int          NUM_SRC    = 8,
   parameter int          SLOT_BYTES = 4,
   parameter logic [PORT_AW-1:0] PORT_SRC = 'h10,
   parameter logic [PORT_AW-1:0] PORT_DLY = 'h11,
   parameter logic [PORT_AW-1:0] PORT_END = 'h20,
   parameter logic [DATA_W-1:0]  PASS_CODE = 'h55
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               io_wr,
   input  logic [PORT_AW-1:0] io_addr,
   input  logic [DATA_W-1:0]  io_wdata,
   input  logic               inta,
   input  logic               rd,
   input  logic [DATA_W-1:0]  vec_rdata,
   output logic               intr,
   output logic [MEM_AW-1:0]  vec_addr,
   output logic [DATA_W-1:0]  ack_data,
   output logic               ack_oe,
   output logic               done,
   output logic               pass
);

   localparam int CNT_W = DATA_W;

   port_hit_t hit;
   logic      fire;

   irq_port_decode #(
      .AW(PORT_AW), .PORT_SRC(PORT_SRC), .PORT_DLY(PORT_DLY), .PORT_END(PORT_END)
   ) u_decode (
      .io_wr(io_wr), .io_addr(io_addr), .hit(hit)
   );

   irq_delay_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(hit.dly), .load_val(io_wdata),
      .fire(fire), .intr(intr)
   );

   irq_vector_feed #(
      .DATA_W(DATA_W), .MEM_AW(MEM_AW), .VEC_BASE(VEC_BASE),
      .NUM_SRC(NUM_SRC), .SLOT_BYTES(SLOT_BYTES)
   ) u_feed (
      .clk(clk), .rst_n(rst_n), .src_wr(hit.src), .src_val(io_wdata),
      .restart(fire), .inta(inta), .rd(rd), .vec_rdata(vec_rdata),
      .vec_addr(vec_addr), .ack_data(ack_data), .ack_oe(ack_oe)
   );

   irq_outcome_latch #(.DATA_W(DATA_W), .PASS_CODE(PASS_CODE)) u_outcome (
      .clk(clk), .rst_n(rst_n), .wr(hit.fin), .wdata(io_wdata),
      .done(done), .pass(pass)
   );

   AST_ONE_PORT_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({hit.src, hit.dly, hit.fin})); // R9
   AST_NO_PULSE_WITHOUT_ARM: assert property (@(posedge clk) disable iff (!rst_n)
      (intr && !$past(intr)) |-> !$past(hit.dly)); // R4

endmodule

// File: tb/irq_stim_port_tb.sv
module irq_stim_port_tb;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        io_wr, inta, rd;
   logic [7:0]  io_addr, io_wdata, vec_rdata, ack_data;
   logic [15:0] vec_addr;
   logic        intr, ack_oe, done, pass;

   int n_chk  = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   irq_stim_port u_dut (
      .clk(clk), .rst_n(rst_n), .io_wr(io_wr), .io_addr(io_addr), .io_wdata(io_wdata),
      .inta(inta), .rd(rd), .vec_rdata(vec_rdata), .intr(intr), .vec_addr(vec_addr),
      .ack_data(ack_data), .ack_oe(ack_oe), .done(done), .pass(pass)
   );

   function automatic logic [7:0] memb(input logic [15:0] a);
      return a[7:0] ^ a[15:8] ^ 8'h5A;
   endfunction

   assign vec_rdata = memb(vec_addr);

   // {source value written, delay}
   localparam logic [15:0] VECS [6] = '{
      {8'h00, 8'd0}, {8'h03, 8'd1}, {8'h0F, 8'd4},
      {8'hFD, 8'd2}, {8'h01, 8'd9}, {8'h0A, 8'd0}
   };

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [7:0] p, input logic [7:0] d, input logic en = 1'b1);
      io_wr = en; io_addr = p; io_wdata = d;
      @(negedge clk);
      io_wr = 1'b0; io_addr = 8'h00; io_wdata = 8'h00;
   endtask

   task automatic do_reset();
      rst_n = 1'b0; io_wr = 1'b0; io_addr = 8'h00; io_wdata = 8'h00; inta = 1'b0; rd = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
   endtask

   // Called at the negedge right after the delay write edge k.
   task automatic see_pulse(input int n, input string req);
      for (int i = 0; i <= n + 1; i++) begin
         chk(req, int'(intr), (i == n + 1) ? 1 : 0);
         if (i <= n) @(negedge clk);
      end
      @(negedge clk);
      chk(req, int'(intr), 0);
   endtask

   task automatic acks(input int s);
      for (int j = 0; j < 3; j++) begin
         if (j == 1) begin
            inta = 1'b1; rd = 1'b0; #1;
            chk("R7 oe idle", int'(ack_oe), 0);
            chk("R7 data idle", int'(ack_data), 0);
            @(negedge clk);
         end
         inta = 1'b1; rd = 1'b1; #1;
         chk("R7 oe", int'(ack_oe), 1);
         chk("R5 R6 addr", int'(vec_addr), 'h40 + s * 4 + j);
         chk("R7 data", int'(ack_data), int'(memb(16'('h40 + s * 4 + j))));
         @(negedge clk);
      end
      inta = 1'b0; rd = 1'b0;
   endtask

   initial begin
      #2000000;
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin
      do_reset();
      @(negedge clk);
      // R1 reset state
      chk("R1 intr", int'(intr), 0);
      chk("R1 oe", int'(ack_oe), 0);
      chk("R1 data", int'(ack_data), 0);
      chk("R1 done", int'(done), 0);
      chk("R1 pass", int'(pass), 0);

      // R2 R5 R6 R7 table walk
      foreach (VECS[v]) begin
         wr(8'h10, VECS[v][15:8]);
         wr(8'h11, VECS[v][7:0]);
         see_pulse(int'(VECS[v][7:0]), "R2 pulse timing");
         acks(int'(VECS[v][10:8]));
      end

      // R3: no second pulse without a new delay write
      for (int i = 0; i < 20; i++) begin
         chk("R3 stays low", int'(intr), 0);
         @(negedge clk);
      end

      // R4: restart while running
      wr(8'h11, 8'd5);
      repeat (2) @(negedge clk);
      wr(8'h11, 8'd3);
      see_pulse(3, "R4 restart");

      // R4: write on the expiry edge suppresses and restarts
      wr(8'h11, 8'd2);
      repeat (2) @(negedge clk);
      wr(8'h11, 8'd1);
      see_pulse(1, "R4 collide");

      // R9: stray writes leave source, countdown and outcome alone
      wr(8'h10, 8'h06);
      wr(8'h11, 8'd0);
      see_pulse(0, "R9 setup");
      wr(8'h12, 8'h01);
      wr(8'h10, 8'h02, 1'b0);
      wr(8'h11, 8'h00, 1'b0);
      wr(8'h20, 8'h55, 1'b0);
      for (int i = 0; i < 6; i++) begin
         chk("R9 no pulse", int'(intr), 0);
         @(negedge clk);
      end
      chk("R9 src kept", int'(vec_addr), 'h40 + 6 * 4);
      chk("R9 done kept", int'(done), 0);

      // R8 outcome latch
      wr(8'h20, 8'hAA);
      chk("R8 done", int'(done), 1);
      chk("R8 fail", int'(pass), 0);
      wr(8'h20, 8'h55);
      chk("R8 sticky done", int'(done), 1);
      chk("R8 sticky pass", int'(pass), 0);
      do_reset();
      @(negedge clk);
      wr(8'h20, 8'h55);
      chk("R8 done pass", int'(done), 1);
      chk("R8 pass", int'(pass), 1);

      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule